// File: doc/BRIEF.md
# Host Port Initialize Control and DMA Register Addressing

This block is the host-facing control slice of a DSP host port. It keeps the two host transfer-mode bits, the receive and transmit request enables and a self-clearing initialize command bit, all written by the host through one control-register write strobe. It also owns the address counter that picks which transmit/receive data byte register a DMA transfer touches. The host therefore needs no external address pins while DMA mode is active.

When the host sets the initialize bit, the block runs the command in the following cycle. It presents updated channel flags to the data path, which registers them from `flag_wr` and `flag_nxt`, and preloads the address counter. It then clears the bit without help. In DMA mode the counter runs in a circle. It steps up on each DMA strobe, and from the top data register (address 7) it jumps back to a start address formed from the mode bits. A pulse marks each pass through the top register. With a two-register window this halves the DSP-side event rate against the host request rate.

Top module: `hpi_host_ctrl`

## Requirements
- R1: After an active-low reset, `init_busy`, `host_mode`, `dma_mode`, `reg_addr`, `flag_wr`, `cmd_illegal` and `word_done` are all 0.
- R2: A `ctrl_we` cycle stores `ctrl_wdata` bit 0 as the receive request enable, bit 1 as the transmit request enable and bits 4:3 as the mode (bit 3 the low mode bit). It drives `host_mode` from the next cycle, and `dma_mode` is 1 whenever the mode is nonzero. Bit 7 set in the write raises `init_busy` in the next cycle.
- R3: `init_busy` stays high for exactly one cycle, the execute cycle, unless a new initialize write lands in that cycle. `flag_wr` is high only in an execute cycle that is not illegal.
- R4: In an execute cycle with the receive enable set, `flag_nxt` bit 0 (receive data full) is 0 and bit 1 (host transmit empty) is 1.
- R5: In an execute cycle with the transmit enable set, `flag_nxt` bit 2 (transmit empty) is 1 and bit 3 (host receive full) is 0. The bits of a channel whose enable is clear pass `flag_in` through, and outside execute cycles `flag_nxt` equals `flag_in`. In interrupt mode (mode 00) both enables apply together.
- R6: At the end of every execute cycle, illegal or not, `reg_addr` loads 0 when the mode is 00 and {1, mode} otherwise.
- R7: A `dma_strobe` outside an execute cycle with `reg_addr` below 7 increments `reg_addr` by one.
- R8: A `dma_strobe` outside an execute cycle with `reg_addr` at 7 reloads `reg_addr` with {1, mode}.
- R9: `word_done` is high exactly in cycles with `dma_strobe`, `reg_addr` at 7 and no execute. In mode 10 it fires on every second strobe, and in mode 11 on every strobe.
- R10: An execute cycle in a nonzero mode with both enables set raises `cmd_illegal`, holds `flag_wr` low and still clears `init_busy`.
- R11: When `dma_strobe` coincides with an execute cycle, the initialize preload wins and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Host control-register write strobe |
| ctrl_wdata | input | 8 | Control write data (enables, mode, initialize) |
| dma_strobe | input | 1 | One DMA byte transfer completed |
| flag_in | input | 4 | Current channel flags from the data path |
| init_busy | output | 1 | Initialize bit, high in the execute cycle |
| host_mode | output | 2 | Stored mode bits |
| dma_mode | output | 1 | Mode is nonzero |
| reg_addr | output | 3 | Data register address from the counter |
| flag_wr | output | 1 | Load strobe for `flag_nxt` |
| flag_nxt | output | 4 | Flag values after the initialize command |
| cmd_illegal | output | 1 | Illegal initialize in DMA mode |
| word_done | output | 1 | Strobe at the top data register |

## Verification
Two functions of this block can hit the same cycle. The initialize preload and a DMA strobe both drive the address counter, and a control write with the initialize bit set can land in the execute cycle of an earlier initialize. The bench provokes both with directed sequences that issue the strobe or the second write exactly one cycle after an initialize write, and with random traffic that mixes writes and strobes freely. A cycle-level bench model judges the outcome: the preload value must appear in `reg_addr`, no step or wrap may appear, and `init_busy` must remain high when re-armed.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

   // Channel flag bit positions, shared by the datapath and this slice
   localparam int FLAG_W      = 4;
   localparam int FLG_RX_FULL = 0;   // DSP receive data full
   localparam int FLG_HTX_EMP = 1;   // host transmit empty
   localparam int FLG_TX_EMP  = 2;   // DSP transmit empty
   localparam int FLG_HRX_FUL = 3;   // host receive full

   // Per-channel flag effects of the initialize command
   localparam logic [FLAG_W-1:0] RX_SET_M = 4'b0010;
   localparam logic [FLAG_W-1:0] RX_CLR_M = 4'b0001;
   localparam logic [FLAG_W-1:0] TX_SET_M = 4'b0100;
   localparam logic [FLAG_W-1:0] TX_CLR_M = 4'b1000;

   typedef struct packed {
      logic       init;
      logic [1:0] mode;
      logic       tx_en;
      logic       rx_en;
   } ctrl_t;

endpackage

// File: rtl/hpi_ctrl_reg.sv
module hpi_ctrl_reg
   import hpi_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 2,
   parameter int POS_RXE  = 0,
   parameter int POS_TXE  = 1,
   parameter int POS_MODE = 3,
   parameter int POS_INIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              init_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              rxe_q,
   output logic              txe_q
);

   localparam int MODE_HI = POS_MODE + MODE_W - 1;

   if (MODE_HI >= DATA_W || POS_INIT >= DATA_W || POS_RXE >= DATA_W || POS_TXE >= DATA_W) begin : g_bad_pos
      $error("hpi_ctrl_reg: field position outside write data");
   end

   logic init_set;
   logic unused_wdata;

   assign init_set     = we && wdata[POS_INIT];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         rxe_q  <= 1'b0;
         txe_q  <= 1'b0;
      end else if (we) begin
         mode_q <= wdata[MODE_HI:POS_MODE];
         rxe_q  <= wdata[POS_RXE];
         txe_q  <= wdata[POS_TXE];
      end
   end

   // The command bit self-clears after its single execute cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        init_q <= 1'b0;
      else if (init_set) init_q <= 1'b1;
      else if (init_q)   init_q <= 1'b0;
   end

   a_r3_init_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      init_q && !init_set |=> !init_q);

   a_r2_init_arms: assert property (@(posedge clk) disable iff (!rst_n)
      init_set |=> init_q);

   a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mode_q));

endmodule

// File: rtl/hpi_init_exec.sv
module hpi_init_exec
   import hpi_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int MODE_W = 2
) (
   input  logic              init_q,
   input  logic [MODE_W-1:0] mode,
   input  logic              rxe,
   input  logic              txe,
   input  logic [FLAG_W-1:0] flag_in,
   output logic              exec,
   output logic              dma_on,
   output logic              illegal,
   output logic              flag_wr,
   output logic [FLAG_W-1:0] flag_nxt,
   output logic [ADDR_W-1:0] preload
);

   localparam int FILL_W = ADDR_W - MODE_W;

   if (FILL_W < 1) begin : g_bad_width
      $error("hpi_init_exec: counter must be wider than the mode field");
   end

   logic [FLAG_W-1:0] set_m;
   logic [FLAG_W-1:0] clr_m;
   logic [ADDR_W-1:0] dma_start;

   assign exec    = init_q;
   assign dma_on  = |mode;
   assign illegal = exec && dma_on && rxe && txe;
   assign flag_wr = exec && !illegal;

   assign set_m = (rxe ? RX_SET_M : '0) | (txe ? TX_SET_M : '0);
   assign clr_m = (rxe ? RX_CLR_M : '0) | (txe ? TX_CLR_M : '0);

   // Each flag bit gets its own set/clear override
   for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
      always_comb begin
         if (flag_wr) flag_nxt[gi] = (flag_in[gi] && !clr_m[gi]) || set_m[gi];
         else         flag_nxt[gi] = flag_in[gi];
      end
   end

   assign dma_start = {{FILL_W{1'b1}}, mode};
   assign preload   = dma_on ? dma_start : '0;

endmodule

// File: rtl/hpi_addr_ctr.sv
module hpi_addr_ctr #(
   parameter int ADDR_W = 3,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic [MODE_W-1:0] mode,
   output logic [ADDR_W-1:0] addr_q,
   output logic              at_top
);

   localparam int                FILL_W = ADDR_W - MODE_W;
   localparam logic [ADDR_W-1:0] TOP    = '1;

   if (FILL_W < 1) begin : g_bad_width
      $error("hpi_addr_ctr: counter must be wider than the mode field");
   end

   logic [ADDR_W-1:0] wrap_val;

   assign at_top   = (addr_q == TOP);
   assign wrap_val = {{FILL_W{1'b1}}, mode};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load)   addr_q <= load_val;
      else if (step) begin
         if (at_top)   addr_q <= wrap_val;
         else          addr_q <= addr_q + 1'b1;
      end
   end

   a_r6_preload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(load_val));

   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && !at_top |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && at_top |=> addr_q[MODE_W-1:0] == $past(mode));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step |=> $stable(addr_q));

endmodule

// File: rtl/hpi_host_ctrl.sv
module hpi_host_ctrl
   import hpi_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int MODE_W   = 2,
   parameter int POS_RXE  = 0,
   parameter int POS_TXE  = 1,
   parameter int POS_MODE = 3,
   parameter int POS_INIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] ctrl_wdata,
   input  logic              dma_strobe,
   input  logic [FLAG_W-1:0] flag_in,
   output logic              init_busy,
   output logic [MODE_W-1:0] host_mode,
   output logic              dma_mode,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              flag_wr,
   output logic [FLAG_W-1:0] flag_nxt,
   output logic              cmd_illegal,
   output logic              word_done
);

   logic              init_q;
   logic              rxe_q;
   logic              txe_q;
   logic              exec;
   logic              at_top;
   logic [ADDR_W-1:0] preload;

   hpi_ctrl_reg #(
      .DATA_W(DATA_W), .MODE_W(MODE_W), .POS_RXE(POS_RXE),
      .POS_TXE(POS_TXE), .POS_MODE(POS_MODE), .POS_INIT(POS_INIT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
      .init_q(init_q), .mode_q(host_mode), .rxe_q(rxe_q), .txe_q(txe_q)
   );

   hpi_init_exec #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_exec (
      .init_q(init_q), .mode(host_mode), .rxe(rxe_q), .txe(txe_q),
      .flag_in(flag_in), .exec(exec), .dma_on(dma_mode),
      .illegal(cmd_illegal), .flag_wr(flag_wr), .flag_nxt(flag_nxt),
      .preload(preload)
   );

   hpi_addr_ctr #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(exec), .load_val(preload),
      .step(dma_strobe), .mode(host_mode), .addr_q(reg_addr), .at_top(at_top)
   );

   assign init_busy = init_q;
   assign word_done = dma_strobe && at_top && !exec;

   a_r10_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_illegal && !(ctrl_we && ctrl_wdata[POS_INIT]) |=> !init_busy);

   a_r10_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_illegal |-> !flag_wr);

   a_r9_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> (&reg_addr) && !init_busy);

   a_r3_flag_wr_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |-> init_busy);

endmodule

// File: tb/hpi_host_ctrl_tb_top.sv
module hpi_host_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctrl_we;
   logic [7:0] ctrl_wdata;
   logic       dma_strobe;
   logic [3:0] flag_in;
   logic       init_busy;
   logic [1:0] host_mode;
   logic       dma_mode;
   logic [2:0] reg_addr;
   logic       flag_wr;
   logic [3:0] flag_nxt;
   logic       cmd_illegal;
   logic       word_done;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // bench model state
   bit       m_init;
   bit [1:0] m_mode;
   bit       m_rxe, m_txe;
   bit [2:0] m_addr;
   string    addr_tag = "R1";
   int       wd_count;

   always #10 clk = ~clk;

   hpi_host_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .dma_strobe(dma_strobe), .flag_in(flag_in), .init_busy(init_busy),
      .host_mode(host_mode), .dma_mode(dma_mode), .reg_addr(reg_addr),
      .flag_wr(flag_wr), .flag_nxt(flag_nxt), .cmd_illegal(cmd_illegal),
      .word_done(word_done)
   );

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic bit [3:0] exp_flags(bit [3:0] fin, bit rxe, bit txe);
      bit [3:0] f = fin;
      if (rxe) begin f[0] = 1'b0; f[1] = 1'b1; end
      if (txe) begin f[2] = 1'b1; f[3] = 1'b0; end
      return f;
   endfunction

   // One cycle: drive at negedge, check combinational/registered outputs, advance model
   task automatic step(bit we, bit [7:0] wd, bit stb, bit [3:0] fin);
      bit exec, ill, fwr, wdn;
      @(negedge clk);
      ctrl_we = we; ctrl_wdata = wd; dma_strobe = stb; flag_in = fin;
      #1;
      exec = m_init;
      ill  = exec && (m_mode != 0) && m_rxe && m_txe;
      fwr  = exec && !ill;
      wdn  = stb && !exec && (m_addr == 3'd7);
      check("R3", "init_busy", init_busy, m_init);
      check("R2", "host_mode", host_mode, m_mode);
      check("R2", "dma_mode", dma_mode, m_mode != 0);
      check("R3", "flag_wr", flag_wr, fwr);
      check(m_txe ? "R5" : "R4", "flag_nxt", flag_nxt,
            fwr ? exp_flags(fin, m_rxe, m_txe) : fin);
      check("R10", "cmd_illegal", cmd_illegal, ill);
      check("R9", "word_done", word_done, wdn);
      check(addr_tag, "reg_addr", reg_addr, m_addr);
      if (word_done) wd_count++;
      @(posedge clk);
      if (exec) begin
         m_addr   = (m_mode == 0) ? 3'd0 : {1'b1, m_mode};
         addr_tag = stb ? "R11" : (ill ? "R10" : "R6");
      end else if (stb) begin
         addr_tag = (m_addr == 3'd7) ? "R8" : "R7";
         m_addr   = (m_addr == 3'd7) ? {1'b1, m_mode} : m_addr + 3'd1;
      end
      if (we && wd[7]) m_init = 1'b1;
      else if (exec)   m_init = 1'b0;
      if (we) begin
         m_mode = wd[4:3]; m_rxe = wd[0]; m_txe = wd[1];
      end
   endtask

   function automatic bit [7:0] cw(bit init, bit [1:0] mode, bit txe, bit rxe);
      return {init, 2'b00, mode, 1'b0, txe, rxe};
   endfunction

   initial begin
      #3_000_000;
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; ctrl_we = 0; ctrl_wdata = 0; dma_strobe = 0; flag_in = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1", "init_busy", init_busy, 0);
      check("R1", "host_mode", host_mode, 0);
      check("R1", "dma_mode", dma_mode, 0);
      check("R1", "reg_addr", reg_addr, 0);
      check("R1", "flag_wr", flag_wr, 0);
      check("R1", "cmd_illegal", cmd_illegal, 0);
      check("R1", "word_done", word_done, 0);
      rst_n = 1'b1;
      m_init = 0; m_mode = 0; m_rxe = 0; m_txe = 0; m_addr = 0;

      // R4/R5 interrupt mode, both enables, then steps from 0 upward (R7) and wrap to 4 (R8)
      step(1, cw(1, 2'b00, 1, 1), 0, 4'b1001);
      step(0, 0, 0, 4'b1001);
      for (int i = 0; i < 9; i++) step(0, 0, 1, 4'b0000);

      // R9: mode 10 halves the rate, mode 11 every strobe
      step(1, cw(1, 2'b10, 0, 1), 0, 4'b0101);
      step(0, 0, 0, 4'b0101);
      wd_count = 0;
      for (int i = 0; i < 8; i++) step(0, 0, 1, 4'b0);
      check("R9", "word_done count mode 10", wd_count, 4);
      step(1, cw(1, 2'b11, 1, 0), 0, 4'b1010);
      step(0, 0, 0, 4'b1010);
      wd_count = 0;
      for (int i = 0; i < 8; i++) step(0, 0, 1, 4'b0);
      check("R9", "word_done count mode 11", wd_count, 8);

      // R10: illegal in DMA mode
      step(1, cw(1, 2'b01, 1, 1), 0, 4'b1111);
      step(0, 0, 1, 4'b1111);
      step(0, 0, 0, 4'b1111);
      check("R10", "reg_addr after illegal", reg_addr, 5);

      // R11: strobe in execute cycle; then re-arm in execute cycle (R3)
      step(1, cw(1, 2'b10, 0, 0), 0, 4'b0110);
      step(0, 0, 1, 4'b0110);
      step(1, cw(1, 2'b00, 1, 0), 0, 4'b0);
      step(1, cw(1, 2'b00, 0, 1), 1, 4'b1111);
      step(0, 0, 1, 4'b1111);
      step(0, 0, 0, 4'b1111);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         bit we = ($urandom % 4) == 0;
         bit [7:0] wd = 8'($urandom);
         step(we, wd, ($urandom % 2) == 1, 4'($urandom));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule